// File: doc/BRIEF.md
# Single-Bitline SRAM Test Sequencer

This block drives the control lines of a column-organised SRAM array and runs test programs on it. Each cell in the array has one bitline, a row read/write word-line, and two write word-lines per column. Every write drives the bitline low. The stored value depends only on which write word-line is raised: line A writes 1 and line B writes 0. The cell-side supply control follows line A.

The block offers three programs:
- **March:** a march test with an all-zero background.
- **Floating-bitline attack:** the bitline is preset to a level and then released onto the internal node that holds the opposite value.
- **Self-loop attack:** the row word-line stays off, and both write word-lines of a column are raised together so the two cell nodes fight.

In every cycle the block presents one operation and the row and column it applies to. It samples the sensed bit during each read and compares it with an expected value. That expected value comes from the program, or, for the self-loop attack, from a configuration lookup table. The first mismatch is latched with its address, and a done flag marks the end of the program.

The analog cell, the supply-assist devices and the sense amplifier all lie outside the block. Its environment turns the operation lines into array signals and returns the sensed bit on `rd_bit`. That bit is combinational with the current read cycle.

Top module: `sbl_test_seq`

## Requirements
- R1: The read cycle drives wl=1, bl_oe=1, bl_lvl=1 (precharge), wwl_a=0, wwl_b=0 and vvss=0. Idle and hold cycles drive all six lines to 0.
- R2: Each write drives wl=1, bl_oe=1 and bl_lvl=0, with exactly one write word-line high. wwl_a=1 writes 1 and wwl_b=1 writes 0. vvss equals wwl_a during every write.
- R3: `prog`=0 (march) first writes 0 to every cell. It then applies w1, r1, w0, r0 to each cell in turn. Cells are visited with the row changing fastest, so a run lasts 5·N cycles. r1 expects 1 and r0 expects 0.
- R4: `prog`=1 (floating attack) uses `tsel` to pick its setup:
  - `tsel`=0 (right pull-up): initial 0, float level 0, attack on wwl_a, background = `bg_val`.
  - `tsel`=1 (left pull-down): initial 0, float level 1, attack on wwl_b, background 1.
  - `tsel`=2 (right pull-down): initial 1, float level 1, attack on wwl_a, background 1.
  - In all three setups vvss=1 during both attack sub-phases.
- R5: A floating-attack pass first writes the background to every cell. Each cell then goes through five steps:
  - a write of the initial value;
  - a precharge of max(`pch_len`,1) cycles with wl=0, bl_oe=1, bl_lvl = float level and no write word-line;
  - a release of max(`rel_len`,1) cycles with bl_oe=0, wl=1 and the attack word-line high;
  - a read that expects the initial value;
  - a write of the background back to the cell.
- R6: `tsel`=3 runs the three floating-attack setups 0, 1 and 2 in that order. Each setup runs its own background fill.
- R7: `prog`=2 (self-loop) works column by column:
  - it writes `bg_val` to every row;
  - it writes `sla_val` at row `sla_row`;
  - it holds wl=0, bl_oe=0 and wwl_a=wwl_b=1 for SLA_CYC cycles, with vvss=`vvss_lvl`;
  - it spends one hold cycle;
  - it reads every row.
- R8: Self-loop reads expect bit {sla_val,bg_val,vvss_lvl} of a lookup table. SLA_TGT_TBL applies at row `sla_row` and SLA_BG_TBL applies at the other rows. With the default tables, configuration (0,0,0) expects 1 everywhere.
- R9: The first read whose sensed bit differs from the expected value sets `fail` and latches `fail_row`/`fail_col`. Later mismatches change none of the three. An accepted start clears `fail`.
- R10: `done` rises in the cycle after the last operation and stays high until the next accepted start. `prog`=3 raises `done` with no operation at all.
- R11: A start is accepted only when the block is idle or done. The program, setup, lengths and values are captured at the accepted start, so a start pulse or a change of those inputs during a run has no effect on that run.
- R12: After reset all lines are 0, and `done` and `fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| prog | input | 2 | Program: 0 march, 1 floating attack, 2 self-loop, 3 none |
| tsel | input | 2 | Floating-attack setup: 0, 1, 2 or 3 for all |
| bg_val | input | 1 | Background value |
| vvss_lvl | input | 1 | Supply level in self-loop mode |
| sla_val | input | 1 | Initial target value in self-loop mode |
| sla_row | input | ROW_W | Target row in self-loop mode |
| pch_len | input | DUR_W | Precharge sub-phase length |
| rel_len | input | DUR_W | Release sub-phase length |
| rd_bit | input | 1 | Sensed read data |
| wl | output | 1 | Row read/write word-line |
| bl_oe | output | 1 | Bitline driver enable |
| bl_lvl | output | 1 | Bitline driven level |
| wwl_a | output | 1 | Column write word-line A (writes 1) |
| wwl_b | output | 1 | Column write word-line B (writes 0) |
| vvss | output | 1 | Column supply control |
| row_addr | output | ROW_W | Row address |
| col_addr | output | COL_W | Column address |
| done | output | 1 | Program finished |
| fail | output | 1 | Mismatch seen |
| fail_row | output | ROW_W | Row of first mismatch |
| fail_col | output | COL_W | Column of first mismatch |

## Verification
The checks that run on every cycle cover the line encoding:
- legal read, write and hold line patterns;
- vvss tracking wwl_a on writes;
- a release always following a precharge;
- both write word-lines on only with wl off and the bitline released;
- the stickiness of `fail`, its address and `done`.

The bench scenarios cover what needs a whole run:
- the operation counts per program and per setup;
- the precharge levels and attack sides;
- the lookup-dependent self-loop results, checked against a behavioural array;
- first-failure selection when two cells are broken;
- immunity to starts and input changes mid-run.

// File: rtl/sbl_tst_pkg.sv
package sbl_tst_pkg;

    typedef enum logic [1:0] {PRG_MARCH, PRG_FBA, PRG_SLA, PRG_NONE} prg_e;
    typedef enum logic [1:0] {TG_PU_R, TG_PD_L, TG_PD_R, TG_ALL} tgt_e;
    typedef enum logic [2:0] {OP_HOLD, OP_RD, OP_W0, OP_W1, OP_PCH, OP_REL, OP_SLA} op_e;
    typedef enum logic [3:0] {
        PH_IDLE, PH_M_FILL, PH_M_ELEM, PH_F_FILL, PH_F_CELL,
        PH_S_FILL, PH_S_TGT, PH_S_ATK, PH_S_GAP, PH_S_RD, PH_DONE
    } phase_e;

    // one operation: lvl = precharge level, side = 1 for line A, vv = supply bit
    typedef struct packed {
        op_e  kind;
        logic lvl;
        logic side;
        logic vv;
    } op_t;

    typedef struct packed {
        logic wl;
        logic bl_oe;
        logic bl_lvl;
        logic wwl_a;
        logic wwl_b;
        logic vvss;
    } lines_t;

    typedef struct packed {
        logic init;
        logic flt;
        logic side;
        logic vv;
        logic bg;
    } fba_set_t;

    localparam op_t OP_IDLE = '{kind: OP_HOLD, lvl: 1'b0, side: 1'b0, vv: 1'b0};

    function automatic op_t wr_op(input logic v);
        op_t o;
        o      = OP_IDLE;
        o.kind = v ? OP_W1 : OP_W0;
        return o;
    endfunction

    function automatic fba_set_t fba_setup(input tgt_e t, input logic bg_in);
        fba_set_t s;
        s.vv = 1'b1;
        case (t)
            TG_PD_L: begin s.init = 1'b0; s.flt = 1'b1; s.side = 1'b0; s.bg = 1'b1; end
            TG_PD_R: begin s.init = 1'b1; s.flt = 1'b1; s.side = 1'b1; s.bg = 1'b1; end
            default: begin s.init = 1'b0; s.flt = 1'b0; s.side = 1'b1; s.bg = bg_in; end
        endcase
        return s;
    endfunction

    function automatic lines_t enc_op(input op_t o);
        lines_t l;
        l = '0;
        case (o.kind)
            OP_RD:  begin l.wl = 1'b1; l.bl_oe = 1'b1; l.bl_lvl = 1'b1; end
            OP_W0:  begin l.wl = 1'b1; l.bl_oe = 1'b1; l.wwl_b = 1'b1; end
            OP_W1:  begin l.wl = 1'b1; l.bl_oe = 1'b1; l.wwl_a = 1'b1; l.vvss = 1'b1; end
            OP_PCH: begin l.bl_oe = 1'b1; l.bl_lvl = o.lvl; l.vvss = o.vv; end
            OP_REL: begin l.wl = 1'b1; l.wwl_a = o.side; l.wwl_b = ~o.side; l.vvss = o.vv; end
            OP_SLA: begin l.wwl_a = 1'b1; l.wwl_b = 1'b1; l.vvss = o.vv; end
            default: l = '0;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/sbl_line_enc.sv
module sbl_line_enc
    import sbl_tst_pkg::*;
(
    input  op_t    op,
    output lines_t lines
);
    always_comb lines = enc_op(op);
endmodule

// File: rtl/sbl_rd_cmp.sv
module sbl_rd_cmp #(
    parameter int ROW_W = 8,
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             rd_en,
    input  logic             exp_bit,
    input  logic             rd_bit,
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic             fail,
    output logic [ROW_W-1:0] fail_row,
    output logic [COL_W-1:0] fail_col
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fail     <= 1'b0;
            fail_row <= '0;
            fail_col <= '0;
        end else if (clr) begin
            fail     <= 1'b0;
            fail_row <= '0;
            fail_col <= '0;
        end else if (rd_en && (rd_bit != exp_bit) && !fail) begin
            fail     <= 1'b1;
            fail_row <= row;
            fail_col <= col;
        end
    end
endmodule

// File: rtl/sbl_seq_fsm.sv
module sbl_seq_fsm
    import sbl_tst_pkg::*;
#(
    parameter int          ROWS        = 256,
    parameter int          COLS        = 128,
    parameter int          DUR_W       = 4,
    parameter int          SLA_CYC     = 2,
    parameter logic [7:0]  SLA_TGT_TBL = 8'hFF,
    parameter logic [7:0]  SLA_BG_TBL  = 8'hFF,
    localparam int         ROW_W       = $clog2(ROWS),
    localparam int         COL_W       = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  prg_e             prog,
    input  tgt_e             tsel,
    input  logic             bg_val,
    input  logic             vvss_lvl,
    input  logic             sla_val,
    input  logic [ROW_W-1:0] sla_row,
    input  logic [DUR_W-1:0] pch_len,
    input  logic [DUR_W-1:0] rel_len,
    output op_t              op,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o,
    output logic             exp_o,
    output logic             done_o,
    output logic             clr_o
);
    localparam int SLA_W = $clog2(SLA_CYC + 1);
    localparam int CNT_W = (DUR_W > SLA_W) ? DUR_W : SLA_W;

    phase_e           ph;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
    logic [2:0]       step;
    logic [CNT_W-1:0] cnt;
    tgt_e             tgt_q;
    logic             all_q, bg_q, vv_q, st_q;
    logic [ROW_W-1:0] srow_q;
    logic [DUR_W-1:0] pch_q, rel_q;

    fba_set_t         fs;
    logic             last_row, last_col, last_cell;
    logic [2:0]       sla_idx;
    logic [CNT_W:0]   cnt_nx, pch_eff, rel_eff;
    logic             idle_like;

    always_comb begin
        fs        = fba_setup(tgt_q, bg_q);
        last_row  = (row == ROW_W'(ROWS - 1));
        last_col  = (col == COL_W'(COLS - 1));
        last_cell = last_row && last_col;
        sla_idx   = {st_q, bg_q, vv_q};
        cnt_nx    = {1'b0, cnt} + 1'b1;
        pch_eff   = (pch_q == '0) ? (CNT_W+1)'(1) : (CNT_W+1)'(pch_q);
        rel_eff   = (rel_q == '0) ? (CNT_W+1)'(1) : (CNT_W+1)'(rel_q);
        idle_like = (ph == PH_IDLE) || (ph == PH_DONE);
        clr_o     = idle_like && start;
        done_o    = (ph == PH_DONE);
        row_o     = (ph == PH_S_TGT) ? srow_q : row;
        col_o     = col;
    end

    // operation presented in the current cycle
    always_comb begin
        op    = OP_IDLE;
        exp_o = 1'b0;
        case (ph)
            PH_M_FILL: op = wr_op(1'b0);
            PH_M_ELEM: begin
                case (step)
                    3'd0:    op = wr_op(1'b1);
                    3'd1:    begin op.kind = OP_RD; exp_o = 1'b1; end
                    3'd2:    op = wr_op(1'b0);
                    default: begin op.kind = OP_RD; exp_o = 1'b0; end
                endcase
            end
            PH_F_FILL: op = wr_op(fs.bg);
            PH_F_CELL: begin
                case (step)
                    3'd0:    op = wr_op(fs.init);
                    3'd1:    begin op.kind = OP_PCH; op.lvl = fs.flt; op.vv = fs.vv; end
                    3'd2:    begin op.kind = OP_REL; op.side = fs.side; op.vv = fs.vv; end
                    3'd3:    begin op.kind = OP_RD; exp_o = fs.init; end
                    default: op = wr_op(fs.bg);
                endcase
            end
            PH_S_FILL: op = wr_op(bg_q);
            PH_S_TGT:  op = wr_op(st_q);
            PH_S_ATK:  begin op.kind = OP_SLA; op.vv = vv_q; end
            PH_S_RD: begin
                op.kind = OP_RD;
                exp_o   = (row == srow_q) ? SLA_TGT_TBL[sla_idx] : SLA_BG_TBL[sla_idx];
            end
            default: op = OP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= PH_IDLE;
            row    <= '0;
            col    <= '0;
            step   <= '0;
            cnt    <= '0;
            tgt_q  <= TG_PU_R;
            all_q  <= 1'b0;
            bg_q   <= 1'b0;
            vv_q   <= 1'b0;
            st_q   <= 1'b0;
            srow_q <= '0;
            pch_q  <= '0;
            rel_q  <= '0;
        end else begin
            case (ph)
                PH_IDLE, PH_DONE: begin
                    if (start) begin
                        row    <= '0;
                        col    <= '0;
                        step   <= '0;
                        cnt    <= '0;
                        all_q  <= (tsel == TG_ALL);
                        tgt_q  <= (tsel == TG_ALL) ? TG_PU_R : tsel;
                        bg_q   <= bg_val;
                        vv_q   <= vvss_lvl;
                        st_q   <= sla_val;
                        srow_q <= sla_row;
                        pch_q  <= pch_len;
                        rel_q  <= rel_len;
                        case (prog)
                            PRG_MARCH: ph <= PH_M_FILL;
                            PRG_FBA:   ph <= PH_F_FILL;
                            PRG_SLA:   ph <= PH_S_FILL;
                            default:   ph <= PH_DONE;
                        endcase
                    end
                end
                PH_M_FILL, PH_F_FILL: begin
                    if (last_cell) begin
                        row <= '0;
                        col <= '0;
                        ph  <= (ph == PH_M_FILL) ? PH_M_ELEM : PH_F_CELL;
                    end else if (last_row) begin
                        row <= '0;
                        col <= col + 1'b1;
                    end else begin
                        row <= row + 1'b1;
                    end
                end
                PH_M_ELEM: begin
                    if (step == 3'd3) begin
                        step <= '0;
                        if (last_cell) begin
                            row <= '0;
                            col <= '0;
                            ph  <= PH_DONE;
                        end else if (last_row) begin
                            row <= '0;
                            col <= col + 1'b1;
                        end else begin
                            row <= row + 1'b1;
                        end
                    end else begin
                        step <= step + 3'd1;
                    end
                end
                PH_F_CELL: begin
                    case (step)
                        3'd1: begin
                            if (cnt_nx >= pch_eff) begin
                                step <= 3'd2;
                                cnt  <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        3'd2: begin
                            if (cnt_nx >= rel_eff) begin
                                step <= 3'd3;
                                cnt  <= '0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        3'd4: begin
                            step <= '0;
                            if (last_cell) begin
                                row <= '0;
                                col <= '0;
                                if (all_q && (tgt_q != TG_PD_R)) begin
                                    tgt_q <= tgt_e'(2'(tgt_q) + 2'd1);
                                    ph    <= PH_F_FILL;
                                end else begin
                                    ph <= PH_DONE;
                                end
                            end else if (last_row) begin
                                row <= '0;
                                col <= col + 1'b1;
                            end else begin
                                row <= row + 1'b1;
                            end
                        end
                        default: step <= step + 3'd1;
                    endcase
                end
                PH_S_FILL: begin
                    if (last_row) begin
                        row <= '0;
                        ph  <= PH_S_TGT;
                    end else begin
                        row <= row + 1'b1;
                    end
                end
                PH_S_TGT: begin
                    cnt <= '0;
                    ph  <= PH_S_ATK;
                end
                PH_S_ATK: begin
                    if (cnt_nx >= (CNT_W+1)'(SLA_CYC)) begin
                        cnt <= '0;
                        ph  <= PH_S_GAP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_S_GAP: begin
                    row <= '0;
                    ph  <= PH_S_RD;
                end
                PH_S_RD: begin
                    if (last_row) begin
                        row <= '0;
                        if (last_col) begin
                            col <= '0;
                            ph  <= PH_DONE;
                        end else begin
                            col <= col + 1'b1;
                            ph  <= PH_S_FILL;
                        end
                    end else begin
                        row <= row + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sbl_test_seq.sv
module sbl_test_seq
    import sbl_tst_pkg::*;
#(
    parameter int         ROWS        = 256,
    parameter int         COLS        = 128,
    parameter int         DUR_W       = 4,
    parameter int         SLA_CYC     = 2,
    parameter logic [7:0] SLA_TGT_TBL = 8'hFF,
    parameter logic [7:0] SLA_BG_TBL  = 8'hFF,
    localparam int        ROW_W       = $clog2(ROWS),
    localparam int        COL_W       = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       prog,
    input  logic [1:0]       tsel,
    input  logic             bg_val,
    input  logic             vvss_lvl,
    input  logic             sla_val,
    input  logic [ROW_W-1:0] sla_row,
    input  logic [DUR_W-1:0] pch_len,
    input  logic [DUR_W-1:0] rel_len,
    input  logic             rd_bit,
    output logic             wl,
    output logic             bl_oe,
    output logic             bl_lvl,
    output logic             wwl_a,
    output logic             wwl_b,
    output logic             vvss,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic             done,
    output logic             fail,
    output logic [ROW_W-1:0] fail_row,
    output logic [COL_W-1:0] fail_col
);
    op_t    cur_op;
    lines_t lines;
    logic   exp_bit, clr;

    sbl_seq_fsm #(
        .ROWS(ROWS), .COLS(COLS), .DUR_W(DUR_W), .SLA_CYC(SLA_CYC),
        .SLA_TGT_TBL(SLA_TGT_TBL), .SLA_BG_TBL(SLA_BG_TBL)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .prog(prg_e'(prog)), .tsel(tgt_e'(tsel)),
        .bg_val(bg_val), .vvss_lvl(vvss_lvl), .sla_val(sla_val), .sla_row(sla_row),
        .pch_len(pch_len), .rel_len(rel_len),
        .op(cur_op), .row_o(row_addr), .col_o(col_addr),
        .exp_o(exp_bit), .done_o(done), .clr_o(clr)
    );

    sbl_line_enc u_enc (.op(cur_op), .lines(lines));

    sbl_rd_cmp #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cmp (
        .clk(clk), .rst(rst), .clr(clr),
        .rd_en(cur_op.kind == OP_RD), .exp_bit(exp_bit), .rd_bit(rd_bit),
        .row(row_addr), .col(col_addr),
        .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
    );

    assign wl     = lines.wl;
    assign bl_oe  = lines.bl_oe;
    assign bl_lvl = lines.bl_lvl;
    assign wwl_a  = lines.wwl_a;
    assign wwl_b  = lines.wwl_b;
    assign vvss   = lines.vvss;
endmodule

// File: rtl/sbl_seq_chk.sv
module sbl_seq_chk #(
    parameter int ROW_W = 8,
    parameter int COL_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             wl,
    input logic             bl_oe,
    input logic             bl_lvl,
    input logic             wwl_a,
    input logic             wwl_b,
    input logic             vvss,
    input logic             done,
    input logic             fail,
    input logic [ROW_W-1:0] fail_row,
    input logic [COL_W-1:0] fail_col
);
    // R1: precharged read cycle raises no write word-line and no supply bit
    assert_read_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (wl && bl_oe && bl_lvl) |-> (!wwl_a && !wwl_b && !vvss));

    // R1: hold cycle keeps supply low
    assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!wl && !bl_oe && !wwl_a && !wwl_b) |-> !vvss);

    // R2: a write has exactly one write word-line and a low bitline
    assert_write_one_wwl_R2: assert property (@(posedge clk) disable iff (rst)
        (wl && bl_oe && !bl_lvl) |-> (wwl_a != wwl_b));

    // R2: supply follows line A on writes
    assert_vvss_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (wl && bl_oe && !bl_lvl) |-> (vvss == wwl_a));

    // R5: a released bitline with word-line on is preceded by precharge or release
    assert_rel_after_pch_R5: assert property (@(posedge clk) disable iff (rst)
        (wl && !bl_oe) |-> ((wwl_a != wwl_b) && $past((!wl && bl_oe) || (wl && !bl_oe))));

    // R7: both write word-lines only with row word-line off and bitline released
    assert_sla_isolated_R7: assert property (@(posedge clk) disable iff (rst)
        (wwl_a && wwl_b) |-> (!wl && !bl_oe));

    // R9: failure flag and its address hold until a new start
    assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (fail && !start) |=> (fail && $stable(fail_row) && $stable(fail_col)));

    // R10: done holds until a new start
    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);
endmodule

bind sbl_test_seq sbl_seq_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst(rst), .start(start),
    .wl(wl), .bl_oe(bl_oe), .bl_lvl(bl_lvl), .wwl_a(wwl_a), .wwl_b(wwl_b), .vvss(vvss),
    .done(done), .fail(fail), .fail_row(fail_row), .fail_col(fail_col)
);

// File: tb/tb_sbl_test_seq.sv
`timescale 1ns/1ps
module tb_sbl_test_seq;
    localparam int         R   = 4;
    localparam int         C   = 4;
    localparam int         N   = R * C;
    localparam int         SC  = 3;
    localparam logic [7:0] TT  = 8'h5B;
    localparam logic [7:0] BT  = 8'hC7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [1:0] prog = '0, tsel = '0;
    logic       bg_val = 1'b0, vvss_lvl = 1'b0, sla_val = 1'b0;
    logic [1:0] sla_row = '0;
    logic [3:0] pch_len = '0, rel_len = '0;
    logic       rd_bit;
    logic       wl, bl_oe, bl_lvl, wwl_a, wwl_b, vvss, done, fail;
    logic [1:0] row_addr, col_addr, fail_row, fail_col;

    always #5 clk = ~clk;

    sbl_test_seq #(.ROWS(R), .COLS(C), .DUR_W(4), .SLA_CYC(SC),
                   .SLA_TGT_TBL(TT), .SLA_BG_TBL(BT)) dut (
        .clk(clk), .rst(rst), .start(start), .prog(prog), .tsel(tsel),
        .bg_val(bg_val), .vvss_lvl(vvss_lvl), .sla_val(sla_val), .sla_row(sla_row),
        .pch_len(pch_len), .rel_len(rel_len), .rd_bit(rd_bit),
        .wl(wl), .bl_oe(bl_oe), .bl_lvl(bl_lvl), .wwl_a(wwl_a), .wwl_b(wwl_b), .vvss(vvss),
        .row_addr(row_addr), .col_addr(col_addr), .done(done), .fail(fail),
        .fail_row(fail_row), .fail_col(fail_col)
    );

    // behavioural array with up to two broken cells
    logic [C-1:0] mem [R];
    logic         inj0 = 1'b0, inj1 = 1'b0;
    logic [1:0]   i0r = '0, i0c = '0, i1r = '0, i1c = '0;
    logic [1:0]   m_srow = '0;
    logic [2:0]   m_idx = '0;

    assign rd_bit = mem[row_addr][col_addr]
                  ^ (inj0 && row_addr == i0r && col_addr == i0c)
                  ^ (inj1 && row_addr == i1r && col_addr == i1c);

    always @(posedge clk) begin
        if (!rst) begin
            if (wl && bl_oe && !bl_lvl && (wwl_a ^ wwl_b))
                mem[row_addr][col_addr] <= wwl_a;
            if (!wl && wwl_a && wwl_b)
                for (int r = 0; r < R; r++)
                    mem[r][col_addr] <= (r == int'(m_srow)) ? TT[m_idx] : BT[m_idx];
        end
    end

    int total = 0, bad = 0, cycles = 0;
    logic wd_hit = 1'b0;

    // monitor counters
    logic mon_on = 1'b0;
    int cyc, n_rd, n_w, n_w0, n_w1, n_pch, n_rel, n_sla, n_hold, n_ill, seq_bad;
    int blk_len, base_tgt;
    logic mon_all;

    function automatic logic exp_flt(input int t);
        return (t == 0) ? 1'b0 : 1'b1;
    endfunction
    function automatic logic exp_side(input int t);
        return (t == 1) ? 1'b0 : 1'b1;
    endfunction

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (mon_on && !done) begin
            int t;
            cyc = cyc + 1;
            t = mon_all ? (cyc - 1) / blk_len : base_tgt;
            if (wl && bl_oe && bl_lvl && !wwl_a && !wwl_b && !vvss) n_rd++;
            else if (wl && bl_oe && !bl_lvl && !wwl_a && wwl_b && !vvss) begin n_w++; n_w0++; end
            else if (wl && bl_oe && !bl_lvl && wwl_a && !wwl_b && vvss) begin n_w++; n_w1++; end
            else if (!wl && bl_oe && !wwl_a && !wwl_b) begin
                n_pch++;
                if (bl_lvl != exp_flt(t) || !vvss) seq_bad++;
            end else if (wl && !bl_oe && (wwl_a ^ wwl_b)) begin
                n_rel++;
                if (wwl_a != exp_side(t) || !vvss) seq_bad++;
            end else if (!wl && !bl_oe && wwl_a && wwl_b) begin
                n_sla++;
                if (vvss != vvss_exp) seq_bad++;
            end else if (!wl && !bl_oe && !bl_lvl && !wwl_a && !wwl_b && !vvss) n_hold++;
            else n_ill++;
        end
    end
    logic vvss_exp = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // run one program; poke issues a start and changes inputs mid-run
    task automatic run(input int p, input int t, input logic bg, input logic vv,
                       input logic sv, input int srow, input int pl, input int rl,
                       input logic poke);
        @(negedge clk);
        prog = 2'(p); tsel = 2'(t); bg_val = bg; vvss_lvl = vv; sla_val = sv;
        sla_row = 2'(srow); pch_len = 4'(pl); rel_len = 4'(rl);
        m_srow = 2'(srow); m_idx = {sv, bg, vv}; vvss_exp = vv;
        start = 1'b1;
        #1;
        cyc = 0; n_rd = 0; n_w = 0; n_w0 = 0; n_w1 = 0; n_pch = 0; n_rel = 0;
        n_sla = 0; n_hold = 0; n_ill = 0; seq_bad = 0;
        mon_all = (t == 3); base_tgt = t;
        blk_len = N * (4 + ((pl == 0) ? 1 : pl) + ((rl == 0) ? 1 : rl));
        mon_on = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        while (!done && !wd_hit) begin
            if (poke && cyc == 6) begin
                start = 1'b1; prog = 2'd3; tsel = 2'd0; bg_val = ~bg;
                vvss_lvl = ~vv; pch_len = 4'd9; rel_len = 4'd9;
            end else begin
                start = 1'b0;
            end
            @(negedge clk); #1;
            if (cycles > 150000) wd_hit = 1'b1;
        end
        start = 1'b0;
        mon_on = 1'b0;
    endtask

    task automatic fill_mem(input logic v);
        for (int r = 0; r < R; r++) mem[r] = {C{v}};
    endtask

    initial begin
        void'($urandom(32'd1234));
        fill_mem(1'b0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk({wl, bl_oe, bl_lvl, wwl_a, wwl_b, vvss} == 6'b0, "R12 lines",
            int'({wl, bl_oe, bl_lvl, wwl_a, wwl_b, vvss}), 0);
        chk(!done && !fail, "R12 done/fail", int'({done, fail}), 0);

        // R3 march, clean array
        run(0, 0, 0, 0, 0, 0, 1, 1, 0);
        chk(cyc == 5 * N, "R3 cycles", cyc, 5 * N);
        chk(n_w0 == 2 * N && n_w1 == N, "R2 write mix", n_w0 * 100 + n_w1, 2 * N * 100 + N);
        chk(n_rd == 2 * N, "R1 reads", n_rd, 2 * N);
        chk(n_ill == 0, "R1 illegal lines", n_ill, 0);
        chk(done && !fail, "R10 done clean", int'({done, fail}), 2);
        repeat (5) @(negedge clk);
        chk(done, "R10 done held", int'(done), 1);

        // R9 march with one broken cell
        inj0 = 1'b1; i0r = 2'd2; i0c = 2'd1;
        run(0, 0, 0, 0, 0, 0, 1, 1, 0);
        chk(fail && fail_row == 2 && fail_col == 1, "R9 march first fail",
            int'({fail, fail_row, fail_col}), int'({1'b1, 2'd2, 2'd1}));
        inj0 = 1'b0;

        // R4 R5 floating attack per setup with random lengths
        for (int t = 0; t < 3; t++) begin
            int pl, rl, pe, re;
            logic b;
            pl = int'($urandom_range(0, 6)); rl = int'($urandom_range(0, 6));
            b  = 1'($urandom_range(0, 1));
            pe = (pl == 0) ? 1 : pl; re = (rl == 0) ? 1 : rl;
            run(1, t, b, 0, 0, 0, pl, rl, 0);
            chk(cyc == N * (4 + pe + re), "R5 cycles", cyc, N * (4 + pe + re));
            chk(n_pch == N * pe && n_rel == N * re, "R5 sub-phase counts",
                n_pch * 1000 + n_rel, N * pe * 1000 + N * re);
            chk(n_w == 3 * N && n_rd == N, "R5 op counts", n_w * 1000 + n_rd, 3 * N * 1000 + N);
            chk(seq_bad == 0, "R4 float level and side", seq_bad, 0);
            chk(!fail, "R5 clean pass", int'(fail), 0);
            // last write restores background at the last cell
            chk(mem[R-1][C-1] == ((t == 0) ? b : 1'b1), "R4 background",
                int'(mem[R-1][C-1]), int'((t == 0) ? b : 1'b1));
        end

        // R6 all three setups, with start and inputs poked mid-run (R11)
        run(1, 3, 0, 0, 0, 0, 2, 3, 1);
        chk(cyc == 3 * N * 9, "R6 cycles all", cyc, 3 * N * 9);
        chk(n_pch == 3 * N * 2 && n_rel == 3 * N * 3, "R11 lengths captured",
            n_pch * 1000 + n_rel, 6 * N * 1000 + 9 * N);
        chk(seq_bad == 0, "R6 setup order", seq_bad, 0);

        // R9 two broken cells: column-major order picks (2,0) first
        inj0 = 1'b1; i0r = 2'd1; i0c = 2'd3;
        inj1 = 1'b1; i1r = 2'd2; i1c = 2'd0;
        run(1, 2, 0, 0, 0, 0, 1, 1, 0);
        chk(fail && fail_row == 2 && fail_col == 0, "R9 earliest mismatch",
            int'({fail, fail_row, fail_col}), int'({1'b1, 2'd2, 2'd0}));
        repeat (3) @(negedge clk);
        chk(fail && fail_row == 2 && fail_col == 0, "R9 fail held",
            int'({fail, fail_row, fail_col}), int'({1'b1, 2'd2, 2'd0}));
        inj0 = 1'b0; inj1 = 1'b0;

        // R7 R8 self-loop, all eight configurations
        for (int k = 0; k < 8; k++) begin
            int sr;
            logic mis;
            sr = int'($urandom_range(0, R - 1));
            run(2, 0, k[1], k[0], k[2], sr, 1, 1, 0);
            chk(cyc == C * (2 * R + 2 + SC), "R7 cycles", cyc, C * (2 * R + 2 + SC));
            chk(n_sla == C * SC && n_hold == C, "R7 attack/hold", n_sla * 100 + n_hold,
                C * SC * 100 + C);
            chk(n_w == C * (R + 1) && n_rd == N && seq_bad == 0, "R7 op counts",
                n_w * 1000 + n_rd, C * (R + 1) * 1000 + N);
            chk(!fail, "R8 lookup match", int'(fail), 0);
            mis = 1'b0;
            for (int c = 0; c < C; c++)
                for (int r = 0; r < R; r++)
                    if (mem[r][c] != ((r == sr) ? TT[k] : BT[k])) mis = 1'b1;
            chk(!mis, "R8 final array", int'(mis), 0);
        end

        // R8 broken cell seen by self-loop read
        inj0 = 1'b1; i0r = 2'd3; i0c = 2'd2;
        run(2, 0, 0, 0, 0, 1, 1, 1, 0);
        chk(fail && fail_row == 3 && fail_col == 2, "R8 self-loop mismatch",
            int'({fail, fail_row, fail_col}), int'({1'b1, 2'd3, 2'd2}));
        inj0 = 1'b0;

        // R10 empty program; R9 start clears fail
        run(3, 0, 0, 0, 0, 0, 1, 1, 0);
        chk(cyc == 0 && done, "R10 empty program", cyc, 0);
        chk(!fail, "R9 cleared by start", int'(fail), 1'b0);

        // R11 march with mid-run poke keeps march counts
        run(0, 0, 0, 0, 0, 0, 1, 1, 1);
        chk(cyc == 5 * N && n_rd == 2 * N, "R11 start ignored", cyc, 5 * N);

        if (wd_hit) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule